// File: doc/BRIEF.md
# Interrupt Controller Identity Registers

This block keeps the two identity values of a single local interrupt controller: the physical ID, which names it as a single target, and the logical ID, which places it in a multi-target group. It also keeps a small destination-format field that tells the delivery logic which logical grouping model is in use. The identity values go out on dedicated output buses to the destination-match logic next to it. Software reaches the three registers through a simple valid/write/address/data port.

The block starts in a legacy mode with 8-bit IDs. In the first clock after reset is released it latches four strap fields (cluster, package, core and thread number) into the physical ID. After that, software may rewrite the physical ID, the logical ID and the format field. Raising the mode request moves the block into an extended mode with 32-bit IDs. At that moment the block builds the logical ID itself from the physical ID, and all three registers become read-only until the next reset.

Top module: `ictl_id_regs`

## Requirements
- R1: While reset is asserted, `ext_mode` is 0, `phys_id` and `logical_id` are 0 and `dest_model` is all ones.
- R2: At the first rising clock edge after reset is released, `phys_id` takes the value {cluster[1:0], package[1:0], core[1:0], thread[1:0]} in bits [7:0], with bits [31:8] zero. Later changes on the strap pins have no effect.
- R3: In legacy mode, a write to offset 0x020 loads `req_wdata[31:24]` into the physical ID. A read of 0x020 returns the ID in bits [31:24], with the other bits zero.
- R4: In legacy mode, a write to offset 0x0D0 loads `req_wdata[31:24]` into the logical ID. A read of 0x0D0 returns it in bits [31:24], with the other bits zero.
- R5: Offset 0x0E0 holds the 4-bit format field in bits [31:28]. It is loaded from `req_wdata[31:28]` in legacy mode, and the other read bits are zero.
- R6: Extended mode is entered at a clock edge where `ext_mode_req` is 1 and the straps are already captured. A request held across reset release therefore takes effect one cycle after the capture. `ext_mode` then stays 1 until reset, whatever the request does.
- R7: At mode entry, `logical_id` becomes {phys_id[19:4], 16-bit one-hot 1 << phys_id[3:0]}.
- R8: In extended mode, writes to all three registers are ignored. A write issued in the same cycle as mode entry is also ignored.
- R9: In extended mode, reads of 0x020 and 0x0D0 return the full 32-bit values.
- R10: A read of any other offset returns zero. Read data comes with `rd_valid` one clock after the request (default latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_cluster | input | 2 | Cluster number strap |
| strap_package | input | 2 | Package number strap |
| strap_core | input | 2 | Core number strap |
| strap_thread | input | 2 | Thread number strap |
| ext_mode_req | input | 1 | Request to enter extended mode |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the register window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| ext_mode | output | 1 | Extended mode active |
| phys_id | output | 32 | Current physical ID |
| logical_id | output | 32 | Current logical ID |
| dest_model | output | 4 | Current destination-format field |

## Verification
Two events can fall in the same clock: a software write to the logical ID and the hardware-generated logical ID at mode entry. The bench raises `ext_mode_req` in the same cycle as a write to 0x0D0. It then expects the derived value and not the written byte, and reads the value back through the port. A second collision comes from holding the mode request high across reset release. The strap capture must land first, and the derived logical ID must be built from the captured straps one cycle later.

// File: rtl/ictl_id_pkg.sv
package ictl_id_pkg;
   localparam int XID_W = 32;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_PHYS = 2'd1,
      SEL_LOG  = 2'd2,
      SEL_FMT  = 2'd3
   } reg_sel_e;

   // Logical ID formed at extended-mode entry: cluster from [19:4], one-hot member from [3:0]
   function automatic logic [XID_W-1:0] derive_logical(input logic [XID_W-1:0] pid);
      logic [15:0] member;
      member = 16'd1 << pid[3:0];
      return {pid[19:4], member};
   endfunction
endpackage

// File: rtl/ictl_strap_capture.sv
module ictl_strap_capture #(
   parameter int FIELD_W = 2,
   localparam int LEG_W = 4 * FIELD_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [3:0][FIELD_W-1:0] fields,
   output logic                   cap_pulse,
   output logic                   captured,
   output logic [LEG_W-1:0]       cap_id
);
   // Field 3 lands in the top bits, field 0 in the bottom bits
   for (genvar g = 0; g < 4; g++) begin : g_pack
      assign cap_id[g*FIELD_W +: FIELD_W] = fields[g];
   end

   // The first edge with reset released is the capture edge
   assign cap_pulse = ~captured;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) captured <= 1'b0;
      else        captured <= 1'b1;
   end
endmodule

// File: rtl/ictl_mode_ctl.sv
module ictl_mode_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_req,
   input  logic captured,
   output logic ext_mode,
   output logic enter_pulse
);
   assign enter_pulse = mode_req & captured & ~ext_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ext_mode <= 1'b0;
      else if (enter_pulse) ext_mode <= 1'b1;
   end
endmodule

// File: rtl/ictl_id_store.sv
module ictl_id_store
   import ictl_id_pkg::*;
#(
   parameter int LEG_W = 8,
   parameter int FMT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_pulse,
   input  logic [LEG_W-1:0] cap_id,
   input  logic             enter_pulse,
   input  logic             ext_mode,
   input  logic             wr_phys,
   input  logic             wr_log,
   input  logic             wr_fmt,
   input  logic [XID_W-1:0] wdata,
   output logic [XID_W-1:0] phys_q,
   output logic [XID_W-1:0] log_q,
   output logic [FMT_W-1:0] fmt_q
);
   logic             locked;
   logic [LEG_W-1:0] wr_byte;

   assign locked  = ext_mode | enter_pulse;
   assign wr_byte = wdata[XID_W-1 -: LEG_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phys_q <= '0;
         log_q  <= '0;
         fmt_q  <= '1;
      end else begin
         if (cap_pulse)               phys_q <= XID_W'(cap_id);
         else if (wr_phys && !locked) phys_q <= XID_W'(wr_byte);

         if (enter_pulse)             log_q <= derive_logical(phys_q);
         else if (wr_log && !locked)  log_q <= XID_W'(wr_byte);

         if (wr_fmt && !locked)       fmt_q <= wdata[XID_W-1 -: FMT_W];
      end
   end
endmodule

// File: rtl/ictl_read_port.sv
module ictl_read_port
   import ictl_id_pkg::*;
#(
   parameter int LEG_W    = 8,
   parameter int FMT_W    = 4,
   parameter int READ_LAT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  reg_sel_e         sel,
   input  logic             ext_mode,
   input  logic [XID_W-1:0] phys_q,
   input  logic [XID_W-1:0] log_q,
   input  logic [FMT_W-1:0] fmt_q,
   output logic             rd_valid,
   output logic [XID_W-1:0] rd_data
);
   localparam int PAD_W = XID_W - LEG_W;
   localparam int FPAD_W = XID_W - FMT_W;

   logic [XID_W-1:0] word;

   always_comb begin
      unique case (sel)
         SEL_PHYS: word = ext_mode ? phys_q : {phys_q[LEG_W-1:0], {PAD_W{1'b0}}};
         SEL_LOG:  word = ext_mode ? log_q  : {log_q[LEG_W-1:0], {PAD_W{1'b0}}};
         SEL_FMT:  word = {fmt_q, {FPAD_W{1'b0}}};
         default:  word = '0;
      endcase
   end

   if (READ_LAT == 0) begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign rd_valid   = rd_req;
      assign rd_data    = rd_req ? word : '0;
   end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
         end else begin
            rd_valid <= rd_req;
            rd_data  <= rd_req ? word : '0;
         end
      end
   end
endmodule

// File: rtl/ictl_id_regs.sv
module ictl_id_regs
   import ictl_id_pkg::*;
#(
   parameter int               FIELD_W  = 2,
   parameter int               FMT_W    = 4,
   parameter int               ADDR_W   = 12,
   parameter int               READ_LAT = 1,
   parameter logic [ADDR_W-1:0] OFF_PHYS = 12'h020,
   parameter logic [ADDR_W-1:0] OFF_LOG  = 12'h0D0,
   parameter logic [ADDR_W-1:0] OFF_FMT  = 12'h0E0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] strap_cluster,
   input  logic [FIELD_W-1:0] strap_package,
   input  logic [FIELD_W-1:0] strap_core,
   input  logic [FIELD_W-1:0] strap_thread,
   input  logic               ext_mode_req,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [XID_W-1:0]   req_wdata,
   output logic               rd_valid,
   output logic [XID_W-1:0]   rd_data,
   output logic               ext_mode,
   output logic [XID_W-1:0]   phys_id,
   output logic [XID_W-1:0]   logical_id,
   output logic [FMT_W-1:0]   dest_model
);
   localparam int LEG_W = 4 * FIELD_W;

   if (FIELD_W < 1 || FIELD_W > 4) begin : g_bad_field
      $error("FIELD_W must lie in 1..4");
   end
   if (FMT_W < 1 || FMT_W > XID_W) begin : g_bad_fmt
      $error("FMT_W out of range");
   end
   if (READ_LAT != 0 && READ_LAT != 1) begin : g_bad_lat
      $error("READ_LAT must be 0 or 1");
   end
   if (OFF_PHYS == OFF_LOG || OFF_PHYS == OFF_FMT || OFF_LOG == OFF_FMT) begin : g_bad_off
      $error("register offsets must differ");
   end

   logic                   cap_pulse, captured, enter_pulse;
   logic [LEG_W-1:0]       cap_id;
   logic [3:0][FIELD_W-1:0] fields;
   reg_sel_e               sel;
   logic                   wr_phys, wr_log, wr_fmt, rd_req;
   logic [XID_W-1:0]       phys_q, log_q;
   logic [FMT_W-1:0]       fmt_q;
   logic                   unused_wdata;

   assign fields       = {strap_cluster, strap_package, strap_core, strap_thread};
   assign unused_wdata = ^req_wdata;

   always_comb begin
      if      (req_addr == OFF_PHYS) sel = SEL_PHYS;
      else if (req_addr == OFF_LOG)  sel = SEL_LOG;
      else if (req_addr == OFF_FMT)  sel = SEL_FMT;
      else                           sel = SEL_NONE;
   end

   assign wr_phys = req_valid & req_write & (sel == SEL_PHYS);
   assign wr_log  = req_valid & req_write & (sel == SEL_LOG);
   assign wr_fmt  = req_valid & req_write & (sel == SEL_FMT);
   assign rd_req  = req_valid & ~req_write;

   ictl_strap_capture #(.FIELD_W(FIELD_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .fields(fields),
      .cap_pulse(cap_pulse), .captured(captured), .cap_id(cap_id)
   );

   ictl_mode_ctl u_mode (
      .clk(clk), .rst_n(rst_n), .mode_req(ext_mode_req), .captured(captured),
      .ext_mode(ext_mode), .enter_pulse(enter_pulse)
   );

   ictl_id_store #(.LEG_W(LEG_W), .FMT_W(FMT_W)) u_store (
      .clk(clk), .rst_n(rst_n), .cap_pulse(cap_pulse), .cap_id(cap_id),
      .enter_pulse(enter_pulse), .ext_mode(ext_mode),
      .wr_phys(wr_phys), .wr_log(wr_log), .wr_fmt(wr_fmt), .wdata(req_wdata),
      .phys_q(phys_q), .log_q(log_q), .fmt_q(fmt_q)
   );

   ictl_read_port #(.LEG_W(LEG_W), .FMT_W(FMT_W), .READ_LAT(READ_LAT)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .sel(sel), .ext_mode(ext_mode),
      .phys_q(phys_q), .log_q(log_q), .fmt_q(fmt_q),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   assign phys_id    = phys_q;
   assign logical_id = log_q;
   assign dest_model = fmt_q;
endmodule

// File: rtl/ictl_id_regs_chk.sv
module ictl_id_regs_chk #(
   parameter int               ADDR_W   = 12,
   parameter int               FMT_W    = 4,
   parameter int               READ_LAT = 1,
   parameter logic [ADDR_W-1:0] OFF_PHYS = 12'h020,
   parameter logic [ADDR_W-1:0] OFF_LOG  = 12'h0D0,
   parameter logic [ADDR_W-1:0] OFF_FMT  = 12'h0E0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ext_mode,
   input logic [31:0]       phys_id,
   input logic [31:0]       logical_id,
   input logic [FMT_W-1:0]  dest_model,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rd_valid,
   input logic [31:0]       rd_data
);
   // R6
   mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_mode |=> ext_mode);

   // R8
   phys_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_mode |=> $stable(phys_id));

   // R8
   log_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_mode |=> $stable(logical_id));

   // R5
   fmt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_mode |=> $stable(dest_model));

   // R7
   derive_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_mode) |-> (logical_id[31:16] == phys_id[19:4]) &&
                          $onehot(logical_id[15:0]) &&
                          logical_id[phys_id[3:0]]);

   // R3
   legacy_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_mode |-> (phys_id[31:8] == 24'd0) && (logical_id[31:8] == 24'd0));

   if (READ_LAT == 1) begin : g_lat1
      // R10
      rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !req_write) |=> rd_valid);

      // R10
      unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !req_write && req_addr != OFF_PHYS &&
          req_addr != OFF_LOG && req_addr != OFF_FMT) |=> (rd_data == 32'd0));
   end
endmodule

bind ictl_id_regs ictl_id_regs_chk #(
   .ADDR_W(ADDR_W), .FMT_W(FMT_W), .READ_LAT(READ_LAT),
   .OFF_PHYS(OFF_PHYS), .OFF_LOG(OFF_LOG), .OFF_FMT(OFF_FMT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .phys_id(phys_id),
   .logical_id(logical_id), .dest_model(dest_model), .req_valid(req_valid),
   .req_write(req_write), .req_addr(req_addr), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/ictl_id_regs_tb.sv
module ictl_id_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  strap_cluster, strap_package, strap_core, strap_thread;
   logic        ext_mode_req = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rd_valid, ext_mode;
   logic [31:0] rd_data, phys_id, logical_id;
   logic [3:0]  dest_model;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;

   ictl_id_regs u_dut (
      .clk(clk), .rst_n(rst_n), .strap_cluster(strap_cluster),
      .strap_package(strap_package), .strap_core(strap_core),
      .strap_thread(strap_thread), .ext_mode_req(ext_mode_req),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .ext_mode(ext_mode), .phys_id(phys_id), .logical_id(logical_id),
      .dest_model(dest_model)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   // Driver: issue read and push the expected word into the scoreboard
   task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Monitor: pop and compare each returned read
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R10: unexpected read data %h expected none", rd_data);
         end else begin
            chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      strap_cluster = 2'd2; strap_package = 2'd1; strap_core = 2'd3; strap_thread = 2'd0;
      repeat (3) @(negedge clk);
      chk("R1 ext_mode", {31'd0, ext_mode}, 32'd0);
      chk("R1 phys_id", phys_id, 32'd0);
      chk("R1 logical_id", logical_id, 32'd0);
      chk("R1 dest_model", {28'd0, dest_model}, 32'hF);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 strap capture", phys_id, 32'h0000_009C);
      strap_cluster = 2'd0; strap_core = 2'd0;
      repeat (2) @(negedge clk);
      chk("R2 straps ignored later", phys_id, 32'h0000_009C);

      bus_read(12'h020, 32'h9C00_0000, "R3 read phys legacy");
      bus_read(12'h0E0, 32'hF000_0000, "R5 read fmt reset");
      bus_read(12'h0D0, 32'h0000_0000, "R4 read log reset");
      bus_read(12'h100, 32'h0000_0000, "R10 unmapped read");
      bus_read(12'h024, 32'h0000_0000, "R10 near-miss offset");

      bus_write(12'h020, 32'h5A12_3456);
      chk("R3 phys write", phys_id, 32'h0000_005A);
      bus_read(12'h020, 32'h5A00_0000, "R3 phys readback");
      bus_write(12'h0D0, 32'h81FF_FFFF);
      chk("R4 log write", logical_id, 32'h0000_0081);
      bus_read(12'h0D0, 32'h8100_0000, "R4 log readback");
      bus_write(12'h0E0, 32'h0FFF_FFFF);
      chk("R5 fmt write", {28'd0, dest_model}, 32'h0);
      bus_read(12'h0E0, 32'h0000_0000, "R5 fmt readback");
      bus_write(12'h100, 32'hFFFF_FFFF);
      chk("R10 unmapped write no effect phys", phys_id, 32'h0000_005A);

      bus_write(12'h020, 32'h3700_0000);
      // Mode entry and a logical-ID write in the same cycle
      @(negedge clk);
      ext_mode_req = 1'b1;
      req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h0D0; req_wdata = 32'hAA00_0000;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      chk("R6 mode entered", {31'd0, ext_mode}, 32'd1);
      chk("R7 derived logical", logical_id, 32'h0003_0080);
      chk("R8 entry-cycle write lost", logical_id, 32'h0003_0080);

      bus_write(12'h020, 32'hFFFF_FFFF);
      bus_write(12'h0D0, 32'h1234_5678);
      bus_write(12'h0E0, 32'hF000_0000);
      chk("R8 phys write ignored", phys_id, 32'h0000_0037);
      chk("R8 log write ignored", logical_id, 32'h0003_0080);
      chk("R8 fmt write ignored", {28'd0, dest_model}, 32'h0);
      bus_read(12'h020, 32'h0000_0037, "R9 phys full read");
      bus_read(12'h0D0, 32'h0003_0080, "R9 log full read");
      bus_read(12'h0E0, 32'h0000_0000, "R5 fmt ext read");
      ext_mode_req = 1'b0;
      repeat (3) @(negedge clk);
      chk("R6 mode sticky", {31'd0, ext_mode}, 32'd1);

      // Second reset with the request held high across release
      ext_mode_req = 1'b1;
      strap_cluster = 2'd0; strap_package = 2'd0; strap_core = 2'd0; strap_thread = 2'd3;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 ext_mode cleared", {31'd0, ext_mode}, 32'd0);
      chk("R1 dest_model reset", {28'd0, dest_model}, 32'hF);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 recapture", phys_id, 32'h0000_0003);
      chk("R6 not yet in capture cycle", {31'd0, ext_mode}, 32'd0);
      @(negedge clk);
      chk("R6 entry after capture", {31'd0, ext_mode}, 32'd1);
      chk("R7 derived from straps", logical_id, 32'h0000_0008);

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL R10: actual %0d pending reads expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule